// File: doc/BRIEF.md
# Dual Compare-Match Timer with Output Toggle Flip-Flop

This block holds a set of up-counting timer channels, two by default, each eight bits wide. Each channel has its own time-constant register. A channel advances its counter on each external count-enable strobe while its run bit is set. When the count equals the constant on an enabled strobe, the counter goes back to zero and the channel raises a one-cycle interrupt pulse on its own line. The timer period is therefore the constant plus one strobes.

One output flip-flop drives the timer-output signal. While its toggle-enable bit is set, it inverts on every match of the channel chosen by a select field. Software can also command it directly. One code forces it high, one forces it low, one inverts it once, and one leaves it as it is. All configuration goes through a write-only port. There is no read path, so the constants and control bits cannot be read back.

Register map (address on `wr_addr`): addresses 0 to N-1 hold the channel time constants. Address N is the run register, where bit i runs channel i. Address N+1 is the flip-flop control register: bits [1:0] hold the command, bit 2 is the toggle enable, and the bits from bit 3 upward select the channel.

Top module: `cmt_timer_pair`

## Requirements
- R1: After reset, every irq line is 0, tmr_out is 0, every counter is 0, every channel is stopped, and match toggling is disabled.
- R2: While a channel runs, its counter advances only on its count-enable strobe. A strobe taken while the count equals the constant reloads the counter to 0 and drives that channel's irq high for exactly the next cycle. From a zeroed counter, matches fall on strobe number constant+1 and on every multiple of it.
- R3: Writing 0 to a channel's run bit holds its counter at 0 and suppresses its irq. Setting the bit again restarts the count from 0.
- R4: The channels are independent. Each irq line reflects only its own channel's constant, run bit and strobe.
- R5: With toggle enable (control bit 2) at 1, tmr_out inverts in the cycle after each match of the channel named by the select field (control bits from 3 up, 0 = channel 0, 1 = channel 1). Matches of other channels leave it unchanged.
- R6: With toggle enable at 0, which is its reset value, matches leave tmr_out unchanged.
- R7: A control write with command 01 sets tmr_out to 1 in the next cycle. Command 10 clears it to 0.
- R8: A control write with command 00 inverts tmr_out once in the next cycle.
- R9: A control write with command 11 leaves tmr_out unchanged in the next cycle, even when a match falls in the same cycle.
- R10: When a control write and a toggling match fall in the same cycle, the written command decides tmr_out, while the match still produces its irq pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| cnt_en | input | 2 | Per-channel count-enable strobes |
| irq | output | 2 | Per-channel one-cycle match pulses |
| tmr_out | output | 1 | Timer output flip-flop value |

## Verification
The bench walks a small constant through two full periods. It checks that the pulse lands on strobe constant+1 and falls after one cycle. A counter that failed to reload, or an irq level that stuck high, would show up there. It stops and restarts a channel mid-count, which catches a counter that holds its value instead of clearing. It runs both channels together with co-prime periods to expose cross-coupled selection. It drives a command write into the same cycle as a toggling match: a design that gave the match priority would end one level off, and a design that treated 11 as an ordinary write would let the coincident match through.

// File: rtl/cmt_pkg.sv
package cmt_pkg;

    // Flip-flop command codes carried in control bits [1:0]
    typedef enum logic [1:0] {
        FF_INV  = 2'b00,
        FF_SET  = 2'b01,
        FF_CLR  = 2'b10,
        FF_KEEP = 2'b11
    } ff_cmd_e;

    // Control register bit positions
    localparam int unsigned CTL_TOG_BIT = 2;
    localparam int unsigned CTL_SEL_LSB = 3;

endpackage

// File: rtl/cmt_regif.sv
module cmt_regif
    import cmt_pkg::*;
#(
    parameter int unsigned N  = 2,
    parameter int unsigned W  = 8,
    parameter int unsigned AW = 3,
    parameter int unsigned SW = 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [AW-1:0]         wr_addr,
    input  logic [W-1:0]          wr_data,
    output logic [N-1:0][W-1:0]   tc,
    output logic [N-1:0]          run,
    output logic                  tog_en,
    output logic [SW-1:0]         sel,
    output logic                  cmd_vld,
    output ff_cmd_e               cmd
);

    localparam logic [AW-1:0] RUN_ADDR = AW'(N);
    localparam logic [AW-1:0] CTL_ADDR = AW'(N + 1);

    typedef struct packed {
        logic [N-1:0][W-1:0] tc;
        logic [N-1:0]        run;
        logic                tog_en;
        logic [SW-1:0]       sel;
    } regs_t;

    regs_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        cmd_vld = 1'b0;
        cmd     = FF_KEEP;
        if (wr_en) begin
            for (int i = 0; i < int'(N); i++) begin
                if (wr_addr == AW'(i)) begin
                    st_d.tc[i] = wr_data;
                end
            end
            if (wr_addr == RUN_ADDR) begin
                st_d.run = wr_data[N-1:0];
            end
            if (wr_addr == CTL_ADDR) begin
                st_d.tog_en = wr_data[CTL_TOG_BIT];
                st_d.sel    = wr_data[CTL_SEL_LSB +: SW];
                cmd_vld     = 1'b1;
                cmd         = ff_cmd_e'(wr_data[1:0]);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tc     = st_q.tc;
    assign run    = st_q.run;
    assign tog_en = st_q.tog_en;
    assign sel    = st_q.sel;

endmodule

// File: rtl/cmt_channel.sv
module cmt_channel #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         cnt_en,
    input  logic [W-1:0] tc,
    output logic         match_evt,
    output logic         irq
);

    typedef struct packed {
        logic [W-1:0] cnt;
        logic         irq;
    } chan_t;

    chan_t st_d, st_q;

    // A match only counts on an enabled strobe of a running channel
    assign match_evt = run && cnt_en && (st_q.cnt == tc);

    always_comb begin
        st_d     = st_q;
        st_d.irq = match_evt;
        if (!run) begin
            st_d.cnt = '0;
        end else if (cnt_en) begin
            st_d.cnt = match_evt ? '0 : st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq = st_q.irq;

endmodule

// File: rtl/cmt_toggle_ff.sv
module cmt_toggle_ff
    import cmt_pkg::*;
#(
    parameter int unsigned N  = 2,
    parameter int unsigned SW = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_vld,
    input  ff_cmd_e       cmd,
    input  logic          tog_en,
    input  logic [SW-1:0] sel,
    input  logic [N-1:0]  match_evt,
    output logic          q
);

    typedef struct packed {
        logic q;
    } ff_t;

    ff_t  st_d, st_q;
    logic sel_hit;

    always_comb begin
        sel_hit = 1'b0;
        for (int i = 0; i < int'(N); i++) begin
            if (sel == SW'(i)) begin
                sel_hit = match_evt[i];
            end
        end
    end

    always_comb begin
        st_d = st_q;
        if (cmd_vld) begin
            unique case (cmd)
                FF_SET:  st_d.q = 1'b1;
                FF_CLR:  st_d.q = 1'b0;
                FF_INV:  st_d.q = ~st_q.q;
                FF_KEEP: st_d.q = st_q.q;
                default: st_d.q = st_q.q;
            endcase
        end else if (tog_en && sel_hit) begin
            st_d.q = ~st_q.q;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign q = st_q.q;

endmodule

// File: rtl/cmt_timer_pair.sv
module cmt_timer_pair
    import cmt_pkg::*;
#(
    parameter int unsigned N  = 2,
    parameter int unsigned W  = 8,
    parameter int unsigned AW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [W-1:0]  wr_data,
    input  logic [N-1:0]  cnt_en,
    output logic [N-1:0]  irq,
    output logic          tmr_out
);

    localparam int unsigned SW = (N > 1) ? $clog2(N) : 1;

    logic [N-1:0][W-1:0] tc_q;
    logic [N-1:0]        run_q;
    logic                tog_en_q;
    logic [SW-1:0]       sel_q;
    logic                cmd_vld;
    ff_cmd_e             cmd;
    logic [N-1:0]        match_evt;

    cmt_regif #(.N(N), .W(W), .AW(AW), .SW(SW)) u_regif (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .tc      (tc_q),
        .run     (run_q),
        .tog_en  (tog_en_q),
        .sel     (sel_q),
        .cmd_vld (cmd_vld),
        .cmd     (cmd)
    );

    for (genvar g = 0; g < int'(N); g++) begin : g_chan
        cmt_channel #(.W(W)) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .run       (run_q[g]),
            .cnt_en    (cnt_en[g]),
            .tc        (tc_q[g]),
            .match_evt (match_evt[g]),
            .irq       (irq[g])
        );
    end

    cmt_toggle_ff #(.N(N), .SW(SW)) u_ff (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_vld   (cmd_vld),
        .cmd       (cmd),
        .tog_en    (tog_en_q),
        .sel       (sel_q),
        .match_evt (match_evt),
        .q         (tmr_out)
    );

endmodule

// File: rtl/cmt_timer_pair_chk.sv
module cmt_timer_pair_chk #(
    parameter int unsigned N  = 2,
    parameter int unsigned W  = 8,
    parameter int unsigned AW = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_en,
    input logic [AW-1:0] wr_addr,
    input logic [W-1:0]  wr_data,
    input logic [N-1:0]  cnt_en,
    input logic [N-1:0]  irq,
    input logic          tmr_out,
    input logic [N-1:0]  run,
    input logic          tog_en
);

    localparam logic [AW-1:0] CTL_ADDR = AW'(N + 1);

    logic ctl_wr;
    assign ctl_wr = wr_en && (wr_addr == CTL_ADDR);

    for (genvar g = 0; g < int'(N); g++) begin : g_chk
        // R2 / R4: a pulse needs this channel's own strobe one cycle earlier
        a_r4_irq_needs_own_strobe: assert property (@(posedge clk) disable iff (!rst_n)
            irq[g] |-> $past(cnt_en[g]));
        // R3: a stopped channel raises no pulse
        a_r3_stopped_is_quiet: assert property (@(posedge clk) disable iff (!rst_n)
            !run[g] |=> !irq[g]);
    end

    a_r6_hold_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        (!tog_en && !ctl_wr) |=> $stable(tmr_out));

    a_r7_set_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && wr_data[1:0] == 2'b01) |=> tmr_out);

    a_r7_clr_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && wr_data[1:0] == 2'b10) |=> !tmr_out);

    a_r8_inv_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && wr_data[1:0] == 2'b00) |=> (tmr_out != $past(tmr_out)));

    a_r9_keep_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && wr_data[1:0] == 2'b11) |=> $stable(tmr_out));

endmodule

bind cmt_timer_pair cmt_timer_pair_chk #(.N(N), .W(W), .AW(AW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .cnt_en  (cnt_en),
    .irq     (irq),
    .tmr_out (tmr_out),
    .run     (run_q),
    .tog_en  (tog_en_q)
);

// File: tb/tb_cmt_timer_pair.sv
`timescale 1ns/1ps
module tb_cmt_timer_pair;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [1:0] cnt_en = '0;
    logic [1:0] irq;
    logic       tmr_out;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #5 clk = ~clk;

    cmt_timer_pair dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .cnt_en(cnt_en), .irq(irq), .tmr_out(tmr_out)
    );

    localparam logic [2:0] A_TC0 = 3'd0, A_TC1 = 3'd1, A_RUN = 3'd2, A_CTL = 3'd3;

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(logic [2:0] a, logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic strobe(logic [1:0] m);
        @(negedge clk);
        cnt_en = m;
        @(negedge clk);
        cnt_en = '0;
    endtask

    task automatic wr_strobe(logic [2:0] a, logic [7:0] d, logic [1:0] m);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d; cnt_en = m;
        @(negedge clk);
        wr_en = 1'b0; cnt_en = '0;
    endtask

    task automatic t_reset();
        check("R1 irq after reset", int'(irq), 0);
        check("R1 tmr_out after reset", int'(tmr_out), 0);
        // Stopped after reset: strobes give no pulse
        strobe(2'b11);
        check("R1 stopped after reset", int'(irq), 0);
        // Toggle disabled after reset: a match leaves tmr_out alone
        wr(A_TC0, 8'd0);
        wr(A_RUN, 8'b01);
        strobe(2'b01);
        check("R6 match gives irq", int'(irq[0]), 1);
        check("R6 no toggle while disabled", int'(tmr_out), 0);
        wr(A_RUN, 8'b00);
    endtask

    task automatic t_period();
        wr(A_TC0, 8'd3);
        wr(A_RUN, 8'b01);
        for (int k = 1; k <= 8; k++) begin
            strobe(2'b01);
            check($sformatf("R2 irq on strobe %0d", k), int'(irq[0]), (k % 4 == 0) ? 1 : 0);
            @(negedge clk);
            check("R2 pulse lasts one cycle", int'(irq[0]), 0);
        end
        repeat (5) @(negedge clk);
        check("R2 no pulse without strobes", int'(irq), 0);
    endtask

    task automatic t_run_stop();
        strobe(2'b01);
        strobe(2'b01);
        wr(A_RUN, 8'b00);
        strobe(2'b01);
        strobe(2'b01);
        check("R3 stopped channel quiet", int'(irq[0]), 0);
        wr(A_RUN, 8'b01);
        for (int k = 1; k <= 4; k++) begin
            strobe(2'b01);
            check($sformatf("R3 restart from zero strobe %0d", k), int'(irq[0]), (k == 4) ? 1 : 0);
        end
        wr(A_RUN, 8'b00);
    endtask

    task automatic t_indep();
        wr(A_TC0, 8'd1);
        wr(A_TC1, 8'd2);
        wr(A_RUN, 8'b11);
        for (int k = 1; k <= 6; k++) begin
            strobe(2'b11);
            check($sformatf("R4 ch0 strobe %0d", k), int'(irq[0]), (k % 2 == 0) ? 1 : 0);
            check($sformatf("R4 ch1 strobe %0d", k), int'(irq[1]), (k % 3 == 0) ? 1 : 0);
        end
        // Only channel 1 strobed: channel 0 stays quiet
        strobe(2'b10);
        check("R4 unstrobed channel quiet", int'(irq[0]), 0);
        wr(A_RUN, 8'b00);
    endtask

    task automatic t_cmds();
        wr(A_CTL, 8'b0000_0001);
        check("R7 set command", int'(tmr_out), 1);
        wr(A_CTL, 8'b0000_0010);
        check("R7 clear command", int'(tmr_out), 0);
        wr(A_CTL, 8'b0000_0000);
        check("R8 invert to one", int'(tmr_out), 1);
        wr(A_CTL, 8'b0000_0000);
        check("R8 invert to zero", int'(tmr_out), 0);
        wr(A_CTL, 8'b0000_0001);
        wr(A_CTL, 8'b0000_0011);
        check("R9 keep command holds one", int'(tmr_out), 1);
    endtask

    task automatic t_toggle();
        logic exp_q;
        // Clear, enable toggling, select channel 0
        wr(A_CTL, 8'b0000_0110);
        wr(A_RUN, 8'b11);
        exp_q = 1'b0;
        for (int k = 1; k <= 6; k++) begin
            strobe(2'b11);
            if (k % 2 == 0) exp_q = ~exp_q;
            check($sformatf("R5 sel0 strobe %0d", k), int'(tmr_out), int'(exp_q));
        end
        // Keep command, toggling on, select channel 1
        wr(A_RUN, 8'b00);
        wr(A_CTL, 8'b0000_1111);
        check("R9 keep with select change", int'(tmr_out), int'(exp_q));
        wr(A_RUN, 8'b11);
        for (int k = 1; k <= 6; k++) begin
            strobe(2'b11);
            if (k % 3 == 0) exp_q = ~exp_q;
            check($sformatf("R5 sel1 strobe %0d", k), int'(tmr_out), int'(exp_q));
        end
        wr(A_RUN, 8'b00);
    endtask

    task automatic t_collide();
        wr(A_TC0, 8'd0);
        wr(A_RUN, 8'b01);
        wr(A_CTL, 8'b0000_0101);
        check("R7 set before collision", int'(tmr_out), 1);
        wr_strobe(A_CTL, 8'b0000_0101, 2'b01);
        check("R10 set wins over toggle", int'(tmr_out), 1);
        check("R10 irq still pulses", int'(irq[0]), 1);
        wr_strobe(A_CTL, 8'b0000_0110, 2'b01);
        check("R10 clear wins over toggle", int'(tmr_out), 0);
        wr_strobe(A_CTL, 8'b0000_0111, 2'b01);
        check("R9 keep wins over toggle", int'(tmr_out), 0);
        strobe(2'b01);
        check("R5 toggle after collisions", int'(tmr_out), 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_period();
        t_run_stop();
        t_indep();
        t_cmds();
        t_toggle();
        t_collide();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule